// File: doc/BRIEF.md
# Byte-Positioned Vector Element Inserter

This block writes one element into a 128-bit destination vector at a byte offset rather than at an element slot. The element is 1, 2, 4 or 8 bytes wide. It comes either from a 64-bit scalar input or from a fixed location inside a 128-bit vector input. The offset can be counted from the most significant end of the register or from the least significant end. Every destination byte that the element does not cover is passed through unchanged.

The datapath is combinational. By default a single output register follows it, so the result is available one clock after the operands. An execution pipeline places the block after operand read and feeds it decoded controls. The block flags one control combination as illegal, and in that case it returns the destination untouched.

Top module: `ins_byte_insert`

## Requirements
- R1: After a synchronous active-low reset, `result` is all zeros and `err` is 0.
- R2: With the default output register, `result` and `err` reflect the inputs sampled at the previous rising clock edge, and not the current inputs.
- R3: The `size` codes are 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes, written n below. With `use_vec` = 0, the element is the low n bytes of `src_scalar`, and all four sizes are legal (`err` = 0).
- R4: With `use_vec` = 1, the element is the low n bytes of bits [127:64] of `src_vec`, which is the rightmost element of its upper doubleword.
- R5: Bytes are numbered 0 to 15 with byte 0 at bits [127:120]. With `rev` = 0, the most significant element byte lands on byte `pos`, and the element continues toward higher byte numbers.
- R6: With `rev` = 1, the element occupies bytes 16−pos−n through 15−pos. Its least significant byte lands on byte 15−pos.
- R7: Every result byte that the element does not cover equals the corresponding byte of `dst`.
- R8: With `rev` = 0, element bytes whose position would exceed 15 are dropped. The element bytes that stay in range are still written.
- R9: With `rev` = 1, element bytes whose position would fall below 0 are dropped. The element bytes that stay in range are still written.
- R10: `use_vec` = 1 together with `size` = 3 is illegal. In that case `err` is 1 and `result` equals `dst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dst | input | 128 | Destination vector that is passed through outside the element |
| src_scalar | input | 64 | Scalar element source |
| src_vec | input | 128 | Vector element source |
| use_vec | input | 1 | 1 selects the vector source |
| size | input | 2 | Element size code |
| rev | input | 1 | 1 counts the position from the low end |
| pos | input | 4 | Byte position, 0 to 15 |
| result | output | 128 | Merged vector |
| err | output | 1 | Illegal control combination |

## Verification
The corner cases are elements that run past either end of the register and the mirrored placement in reverse mode. A design that wraps bytes modulo 16 instead of dropping them would corrupt the opposite end of the vector. A design that mirrors only the start position, without subtracting the element size, would shift the element by n−1 bytes. The bench also uses the vector source to catch a design that takes the element from bits [7:0] instead of from the upper doubleword. It checks the illegal doubleword-from-vector case for an error flag with no write to the destination, and it checks that the scalar doubleword stays legal.

// File: rtl/ins_pkg.sv
// Package: shared types and helpers for the byte-positioned inserter.
// Assumes: size codes are powers of two in bytes (code k means 2**k bytes).
package ins_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } ins_size_e;

    // Number of bytes for a size code.
    function automatic int unsigned size_bytes(input ins_size_e sz);
        return 32'd1 << sz;
    endfunction

endpackage

// File: rtl/ins_elem_pick.sv
// Module: ins_elem_pick
// Chooses the 64-bit element carrier (scalar or upper doubleword of the vector)
// and flags the illegal vector/doubleword combination.
// Assumes: the element occupies the low bytes of the returned carrier.
module ins_elem_pick
    import ins_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int SCL_W = 64
) (
    input  logic [SCL_W-1:0] src_scalar,
    input  logic [VEC_W-1:0] src_vec,
    input  logic             use_vec,
    input  ins_size_e        size,
    output logic [SCL_W-1:0] elem,
    output logic             illegal
);

    // Carrier select: the upper doubleword of the vector, or the scalar.
    always_comb begin
        if (use_vec) begin
            elem = src_vec[VEC_W-1 -: SCL_W];
        end else begin
            elem = src_scalar;
        end
    end

    // Legality: a vector source cannot supply a full doubleword element.
    always_comb begin
        illegal = use_vec && (size == SZ_DWORD);
    end

endmodule

// File: rtl/ins_lane_map.sv
// Module: ins_lane_map
// For every destination byte lane, decides whether the element writes it and
// which element byte (counted from the carrier LSB) it receives.
// Assumes: lane 0 is the most significant byte; out-of-range bytes are dropped.
module ins_lane_map
    import ins_pkg::*;
#(
    parameter int NBYTES = 16,
    parameter int EBYTES = 8,
    localparam int POS_W = $clog2(NBYTES),
    localparam int SEL_W = $clog2(EBYTES)
) (
    input  ins_size_e              size,
    input  logic                   rev,
    input  logic [POS_W-1:0]       pos,
    output logic [NBYTES-1:0]      wen,
    output logic [SEL_W-1:0]       sel [NBYTES]
);

    int n_bytes;
    int start;

    // Element start lane; negative when a reverse insert overhangs the top.
    always_comb begin
        n_bytes = int'(size_bytes(size));
        if (rev) begin
            start = NBYTES - int'(pos) - n_bytes;
        end else begin
            start = int'(pos);
        end
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        int k;
        // Lane b: offset of this lane inside the element and its byte select.
        always_comb begin
            k      = b - start;
            wen[b] = (k >= 0) && (k < n_bytes);
            if (wen[b]) begin
                sel[b] = SEL_W'(n_bytes - 1 - k);
            end else begin
                sel[b] = '0;
            end
        end
    end

    // Bound checks on the lane enables.
    always_comb begin
        assert_lane_bound_R8: assert ($countones(wen) <= n_bytes)
            else $error("more lanes written than element bytes");
        if (!rev && (int'(pos) + n_bytes <= NBYTES)) begin
            assert_full_fit_R5: assert ($countones(wen) == n_bytes)
                else $error("in-range natural insert lost bytes");
        end
        if (rev && (int'(pos) + n_bytes <= NBYTES)) begin
            assert_rev_fit_R6: assert ($countones(wen) == n_bytes)
                else $error("in-range reverse insert lost bytes");
        end
    end

endmodule

// File: rtl/ins_byte_merge.sv
// Module: ins_byte_merge
// Merges element bytes into the destination on enabled lanes; an illegal
// request suppresses every write so the destination passes through.
// Assumes: sel indexes bytes of elem counted from its least significant byte.
module ins_byte_merge #(
    parameter int NBYTES = 16,
    parameter int EBYTES = 8,
    localparam int VEC_W = NBYTES * 8,
    localparam int ELM_W = EBYTES * 8,
    localparam int SEL_W = $clog2(EBYTES)
) (
    input  logic [VEC_W-1:0]  dst,
    input  logic [ELM_W-1:0]  elem,
    input  logic [NBYTES-1:0] wen,
    input  logic [SEL_W-1:0]  sel [NBYTES],
    input  logic              illegal,
    output logic [VEC_W-1:0]  merged
);

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        localparam int LO = 8 * (NBYTES - 1 - b);
        // Lane b: element byte when written, destination byte otherwise.
        always_comb begin
            if (wen[b] && !illegal) begin
                merged[LO +: 8] = elem[8*sel[b] +: 8];
            end else begin
                merged[LO +: 8] = dst[LO +: 8];
            end
        end
    end

endmodule

// File: rtl/ins_byte_insert.sv
// Module: ins_byte_insert (top)
// Inserts a 1/2/4/8-byte element into a vector at a byte position counted
// from either end, with an optional output register (OUT_REG).
// Assumes: position alignment is the caller's concern; misaligned positions
// are still placed byte-exactly by the same rule.
module ins_byte_insert
    import ins_pkg::*;
#(
    parameter int VEC_W   = 128,
    parameter int SCL_W   = 64,
    parameter bit OUT_REG = 1'b1,
    localparam int NBYTES = VEC_W / 8,
    localparam int EBYTES = SCL_W / 8,
    localparam int POS_W  = $clog2(NBYTES),
    localparam int SEL_W  = $clog2(EBYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] dst,
    input  logic [SCL_W-1:0] src_scalar,
    input  logic [VEC_W-1:0] src_vec,
    input  logic             use_vec,
    input  logic [1:0]       size,
    input  logic             rev,
    input  logic [POS_W-1:0] pos,
    output logic [VEC_W-1:0] result,
    output logic             err
);

    ins_size_e          size_e;
    logic [SCL_W-1:0]   elem;
    logic               illegal;
    logic [NBYTES-1:0]  wen;
    logic [SEL_W-1:0]   sel [NBYTES];
    logic [VEC_W-1:0]   merged;

    // Size code to internal enumeration.
    always_comb begin
        size_e = ins_size_e'(size);
    end

    ins_elem_pick #(
        .VEC_W (VEC_W),
        .SCL_W (SCL_W)
    ) u_pick (
        .src_scalar (src_scalar),
        .src_vec    (src_vec),
        .use_vec    (use_vec),
        .size       (size_e),
        .elem       (elem),
        .illegal    (illegal)
    );

    ins_lane_map #(
        .NBYTES (NBYTES),
        .EBYTES (EBYTES)
    ) u_map (
        .size (size_e),
        .rev  (rev),
        .pos  (pos),
        .wen  (wen),
        .sel  (sel)
    );

    ins_byte_merge #(
        .NBYTES (NBYTES),
        .EBYTES (EBYTES)
    ) u_merge (
        .dst     (dst),
        .elem    (elem),
        .wen     (wen),
        .sel     (sel),
        .illegal (illegal),
        .merged  (merged)
    );

    if (OUT_REG) begin : g_reg
        // Output register with synchronous active-low reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                result <= '0;
                err    <= 1'b0;
            end else begin
                result <= merged;
                err    <= illegal;
            end
        end

        assert_illegal_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
            err |-> (result == $past(dst)))
            else $error("illegal request modified destination");

        assert_scalar_dword_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!use_vec && size == 2'd3) |=> !err)
            else $error("scalar doubleword flagged illegal");

        assert_last_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!use_vec && !rev && size == 2'd0 && pos == POS_W'(NBYTES-1)) |=>
            (result[7:0] == $past(src_scalar[7:0]) &&
             result[VEC_W-1:8] == $past(dst[VEC_W-1:8])))
            else $error("natural byte insert at last lane wrong");

        assert_rev_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!use_vec && rev && size == 2'd0 && pos == '0) |=>
            (result[7:0] == $past(src_scalar[7:0])))
            else $error("reverse byte insert at position 0 wrong");
    end else begin : g_comb
        // Combinational output.
        always_comb begin
            result = merged;
            err    = illegal;
        end
    end

endmodule

// File: tb/sim_ins_byte_insert.sv
module sim_ins_byte_insert;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [127:0] dst;
    logic [63:0]  src_scalar;
    logic [127:0] src_vec;
    logic         use_vec;
    logic [1:0]   size;
    logic         rev;
    logic [3:0]   pos;
    logic [127:0] result;
    logic         err;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ins_byte_insert u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .dst        (dst),
        .src_scalar (src_scalar),
        .src_vec    (src_vec),
        .use_vec    (use_vec),
        .size       (size),
        .rev        (rev),
        .pos        (pos),
        .result     (result),
        .err        (err)
    );

    localparam logic [127:0] DST = 128'h00112233445566778899AABBCCDDEEFF;
    localparam logic [63:0]  SCL = 64'h0123456789ABCDEF;
    localparam logic [127:0] VEC = 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F;

    // Control vectors {use_vec, rev, size[1:0], pos[3:0]}.
    localparam logic [7:0] TBL [16] = '{
        8'b0_0_00_0000, 8'b0_0_01_0110, 8'b0_0_10_1000, 8'b0_0_11_0000,
        8'b0_1_00_0101, 8'b0_1_01_0010, 8'b0_1_10_0100, 8'b0_1_11_1000,
        8'b1_0_00_0111, 8'b1_0_01_1100, 8'b1_0_10_0100, 8'b1_1_10_1100,
        8'b0_0_11_1100, 8'b0_1_10_1110, 8'b1_1_01_1111, 8'b1_0_11_0000
    };

    // Expected result from the requirements: place element bytes one by one.
    function automatic logic [127:0] expect_res(
        input logic [127:0] d, input logic [63:0] s, input logic [127:0] v,
        input logic uv, input logic rv, input logic [1:0] sz, input logic [3:0] p);
        logic [127:0] r;
        logic [63:0]  carrier;
        int n;
        int first;
        r = d;
        if (uv && sz == 2'd3) return r;
        carrier = uv ? v[127:64] : s;
        n = 1 << sz;
        first = rv ? (16 - int'(p) - n) : int'(p);
        for (int k = 0; k < n; k++) begin
            int lane;
            lane = first + k;
            if (lane >= 0 && lane <= 15)
                r[8*(15-lane) +: 8] = carrier[8*(n-1-k) +: 8];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(input logic uv, input logic rv, input logic [1:0] sz, input logic [3:0] p);
        @(negedge clk);
        use_vec = uv; rev = rv; size = sz; pos = p;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; dst = DST; src_scalar = SCL; src_vec = VEC;
        use_vec = 1'b0; rev = 1'b0; size = 2'd0; pos = 4'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 result", result, '0);
        check("R1 err", {127'd0, err}, '0);
        rst_n = 1'b1;

        // Table walk (R3, R4, R5, R6, R7, R8, R9, R10).
        for (int i = 0; i < 16; i++) begin
            logic [7:0] t;
            t = TBL[i];
            drive(t[7], t[6], t[5:4], t[3:0]);
            check("R3/R4/R5/R6/R7 table", result,
                  expect_res(DST, SCL, VEC, t[7], t[6], t[5:4], t[3:0]));
            check("R10 table err", {127'd0, err}, {127'd0, (t[7] && t[5:4] == 2'd3)});
        end

        // Directed corner cases with hand values.
        drive(1'b0, 1'b0, 2'd0, 4'd0);
        check("R5 byte at lane 0", result, 128'hEF112233445566778899AABBCCDDEEFF);
        drive(1'b0, 1'b1, 2'd1, 4'd0);
        check("R6 reverse half at 0", result, 128'h00112233445566778899AABBCCDDCDEF);
        drive(1'b0, 1'b0, 2'd2, 4'd14);
        check("R8 natural overhang", result, 128'h00112233445566778899AABBCCDD89AB);
        drive(1'b0, 1'b1, 2'd3, 4'd12);
        check("R9 reverse overhang", result, 128'h89ABCDEF445566778899AABBCCDDEEFF);
        drive(1'b1, 1'b0, 2'd2, 4'd4);
        check("R4 vector word", result, 128'h00112233B4A596878899AABBCCDDEEFF);
        drive(1'b0, 1'b0, 2'd3, 4'd4);
        check("R3 scalar dword", result, 128'h001122330123456789ABCDEFCCDDEEFF);
        check("R3 scalar dword err", {127'd0, err}, '0);
        drive(1'b1, 1'b0, 2'd3, 4'd0);
        check("R10 illegal passthrough", result, DST);
        check("R10 illegal err", {127'd0, err}, 128'd1);

        // R2: new inputs are not visible before the next rising edge.
        @(negedge clk);
        use_vec = 1'b0; rev = 1'b0; size = 2'd0; pos = 4'd0;
        #1;
        check("R2 held before edge", result, DST);
        @(negedge clk);
        check("R2 updated after edge", result, 128'hEF112233445566778899AABBCCDDEEFF);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule